// File: doc/BRIEF.md
# Burst Address Sequencer for a 32-bit Bus Target

This block keeps track of the address inside a burst on a 32-bit bus target. On the address-phase strobe it captures the start address, whether the access goes to memory or I/O space, and the configured cache line size. After that it produces the address for each data phase. Every completed data phase moves the address on, either linearly or by wrapping inside a cache line.

For memory accesses the two lowest address bits are not part of the address. They carry a burst-order code:
- `00` selects linear order.
- `10` selects cache-line wrap.
- `01` and `11` are unsupported. For these the target must ask to disconnect once the first data phase has completed.

For I/O accesses the two low bits are a real byte address. The block checks that the active-low byte enables agree with that byte address and reports a mismatch on a one-cycle error flag.

Bus handshaking, select timing and data storage belong to the surrounding target logic.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is active and after it is released, `cur_addr` is 0 and `disc_req` and `be_err` are 0.
- R2: The clock edge that samples `addr_valid` loads `cur_addr`. For a memory access (`io_space`=0) the loaded value is `addr_in` with bits 1:0 cleared. For an I/O access it is `addr_in` unchanged.
- R3: With code `00` the address grows by 4 at the edge after each cycle with `phase_done`=1. In all other cycles it holds.
- R4: With code `01` or `11`, `disc_req` is 1 in the cycle in which the first `phase_done` is high. It stays 1 until the next `addr_valid`. With codes `00` and `10` and a legal line size, `disc_req` stays 0.
- R5: With code `10` (wrap) and a line of L DWORDs, the DWORD offset within the line steps up by one modulo L on each data phase.
- R6: After L data phases in wrap mode, the next address is the following line's base plus the starting offset. Example for L=4 and start 0x08: 0x08, 0x0C, 0x00, 0x04, 0x18.
- R7: A wrap burst that starts on a line boundary produces the same addresses as a linear burst.
- R8: When parameter `WRAP_EN`=0, code `10` behaves like a reserved code. It disconnects after the first data phase, and the address steps linearly.
- R9: `line_dw` is sampled only at the address phase. Changing it during a burst has no effect on that burst.
- R10: A `line_dw` value that is not 2, 4, 8 or 16 turns code `10` into linear order without a disconnect.
- R11: For I/O, let k be `addr_in[1:0]`. Lane k (`be_n[k]`=0) must be enabled, and every lane below k must be disabled (1). Lanes above k are free. A violation sets `be_err` to 1 for exactly the cycle after the address phase, and the address still loads.
- R12: I/O accesses ignore the order code. They step by 4, keep bits 1:0, and never raise `disc_req`.
- R13: When `addr_valid` and `phase_done` are both high in the same cycle, the address phase wins and `phase_done` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_valid | input | 1 | Address-phase strobe |
| addr_in | input | 32 | Address presented in the address phase |
| io_space | input | 1 | 1 selects I/O space, 0 selects memory space |
| be_n | input | 4 | Active-low byte enables for the first data phase |
| phase_done | input | 1 | A data phase completed this cycle |
| line_dw | input | 5 | Cache line size in DWORDs |
| cur_addr | output | 32 | Address of the current data phase |
| disc_req | output | 1 | Target must disconnect |
| be_err | output | 1 | I/O byte-enable mismatch, one-cycle pulse |

## Verification
Wrap bursts are run with line sizes of 2, 4, 8 and 16 DWORDs and with start offsets at the middle, the last DWORD and the first DWORD of a line. These runs separate correct in-line wrapping from rolling over into the next line, and they show that the move to the next line returns to the starting offset rather than to offset 0.

Linear, reserved and no-wrap instances are fed the same stimulus, so a disconnect coming from the wrong code is exposed. Illegal line sizes, and a line size changed in the middle of a burst, confirm that the sampled value alone controls the sequence. The I/O cases cover each byte address with both a legal enable pattern and an illegal one.

// File: rtl/burst_seq_pkg.sv
`timescale 1ns/1ps
package burst_seq_pkg;
  typedef enum logic [1:0] {
    ORD_LINEAR = 2'd0,
    ORD_WRAP   = 2'd1,
    ORD_RSVD   = 2'd2
  } order_e;
endpackage

// File: rtl/burst_be_check.sv
`timescale 1ns/1ps
// Checks active-low byte enables against an I/O byte address.
module burst_be_check #(
  parameter int LANES = 4,
  localparam int SEL_W = $clog2(LANES)
) (
  input  logic [SEL_W-1:0] byte_sel,
  input  logic [LANES-1:0] be_n,
  output logic             mismatch
);
  logic [LANES-1:0] lane_ok;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    localparam logic [SEL_W-1:0] LANE_IDX = SEL_W'(j);
    always_comb begin
      if (byte_sel == LANE_IDX)
        lane_ok[j] = ~be_n[j];          // addressed lane must be on
      else if (LANE_IDX < byte_sel)
        lane_ok[j] = be_n[j];           // lanes below must be off
      else
        lane_ok[j] = 1'b1;              // lanes above are free
    end
  end

  assign mismatch = ~(&lane_ok);
endmodule

// File: rtl/burst_order_decode.sv
`timescale 1ns/1ps
// Turns the address-phase code into an ordering mode.
module burst_order_decode
  import burst_seq_pkg::*;
#(
  parameter bit WRAP_EN = 1'b1
) (
  input  logic       io_space,
  input  logic [1:0] code,
  input  logic       line_ok,
  output order_e     order
);
  always_comb begin
    order = ORD_LINEAR;
    if (!io_space) begin
      unique case (code)
        2'b00: order = ORD_LINEAR;
        2'b10: begin
          if (!WRAP_EN)     order = ORD_RSVD;
          else if (line_ok) order = ORD_WRAP;
          else              order = ORD_LINEAR;
        end
        default: order = ORD_RSVD;
      endcase
    end
  end
endmodule

// File: rtl/burst_addr_step.sv
`timescale 1ns/1ps
// Computes the address following the current data phase.
module burst_addr_step
  import burst_seq_pkg::*;
#(
  parameter int AW    = 32,
  parameter int OFF_W = 4
) (
  input  logic [AW-1:0]    cur,
  input  order_e           order,
  input  logic [OFF_W-1:0] mask,
  input  logic [OFF_W-1:0] start_off,
  input  logic [OFF_W-1:0] cnt,
  output logic [AW-1:0]    nxt,
  output logic [OFF_W-1:0] cnt_nxt
);
  localparam int PAD = AW - OFF_W - 2;

  logic [AW-1:0]    span;
  logic [AW-1:0]    base;
  logic [OFF_W-1:0] cur_off;
  logic [OFF_W-1:0] nxt_off;
  logic [AW-1:0]    in_line;
  logic [AW-1:0]    next_line;
  logic             line_end;

  assign span      = {{PAD{1'b0}}, mask, 2'b11};
  assign base      = cur & ~span;
  assign cur_off   = cur[OFF_W+1:2] & mask;
  assign nxt_off   = (cur_off + 1'b1) & mask;
  assign in_line   = base | {{PAD{1'b0}}, nxt_off, 2'b00};
  assign next_line = (base + span + AW'(1)) | {{PAD{1'b0}}, start_off, 2'b00};
  assign line_end  = (cnt == mask);

  always_comb begin
    nxt     = cur + AW'(4);
    cnt_nxt = cnt;
    if (order == ORD_WRAP) begin
      if (line_end) begin
        nxt     = next_line;
        cnt_nxt = '0;
      end else begin
        nxt     = in_line;
        cnt_nxt = cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/burst_addr_seq.sv
`timescale 1ns/1ps
// Burst address sequencer: top level.
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int AW          = 32,
  parameter int MAX_LINE_DW = 16,
  parameter bit WRAP_EN     = 1'b1,
  localparam int OFF_W      = $clog2(MAX_LINE_DW),
  localparam int LS_W       = OFF_W + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            addr_valid,
  input  logic [AW-1:0]   addr_in,
  input  logic            io_space,
  input  logic [3:0]      be_n,
  input  logic            phase_done,
  input  logic [LS_W-1:0] line_dw,
  output logic [AW-1:0]   cur_addr,
  output logic            disc_req,
  output logic            be_err
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // clock enables
  logic load_en;
  logic step_en;
  assign load_en = addr_valid;
  assign step_en = phase_done & ~addr_valid;

  // address-phase decode
  logic             line_ok;
  logic [OFF_W-1:0] line_mask;
  order_e           order_dec;
  logic             be_mismatch;

  assign line_ok   = (line_dw >= LS_W'(2)) && (line_dw <= LS_W'(MAX_LINE_DW)) && $onehot(line_dw);
  assign line_mask = OFF_W'(line_dw - LS_W'(1));

  burst_order_decode #(.WRAP_EN(WRAP_EN)) u_decode (
    .io_space (io_space),
    .code     (addr_in[1:0]),
    .line_ok  (line_ok),
    .order    (order_dec)
  );

  burst_be_check #(.LANES(4)) u_be (
    .byte_sel (addr_in[1:0]),
    .be_n     (be_n),
    .mismatch (be_mismatch)
  );

  // state
  logic [AW-1:0]    cur_q,   cur_d;
  order_e           order_q, order_d;
  logic [OFF_W-1:0] mask_q,  mask_d;
  logic [OFF_W-1:0] start_q, start_d;
  logic [OFF_W-1:0] cnt_q,   cnt_d;
  logic             io_q,    io_d;
  logic             done_q,  done_d;
  logic             err_q,   err_d;

  logic [AW-1:0]    step_addr;
  logic [OFF_W-1:0] step_cnt;

  burst_addr_step #(.AW(AW), .OFF_W(OFF_W)) u_step (
    .cur       (cur_q),
    .order     (order_q),
    .mask      (mask_q),
    .start_off (start_q),
    .cnt       (cnt_q),
    .nxt       (step_addr),
    .cnt_nxt   (step_cnt)
  );

  // next state
  always_comb begin
    cur_d   = cur_q;
    order_d = order_q;
    mask_d  = mask_q;
    start_d = start_q;
    cnt_d   = cnt_q;
    io_d    = io_q;
    done_d  = done_q;
    err_d   = load_en & io_space & be_mismatch;
    if (load_en) begin
      cur_d   = io_space ? addr_in : {addr_in[AW-1:2], 2'b00};
      order_d = order_dec;
      mask_d  = line_ok ? line_mask : '0;
      start_d = addr_in[OFF_W+1:2] & (line_ok ? line_mask : '0);
      cnt_d   = '0;
      io_d    = io_space;
      done_d  = 1'b0;
    end else if (step_en) begin
      cur_d   = step_addr;
      cnt_d   = step_cnt;
      done_d  = 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cur_q   <= '0;
      order_q <= ORD_LINEAR;
      mask_q  <= '0;
      start_q <= '0;
      cnt_q   <= '0;
      io_q    <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      cur_q   <= cur_d;
      order_q <= order_d;
      mask_q  <= mask_d;
      start_q <= start_d;
      cnt_q   <= cnt_d;
      io_q    <= io_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign cur_addr = cur_q;
  assign be_err   = err_q;
  assign disc_req = (order_q == ORD_RSVD) & (done_q | phase_done);
endmodule

// File: rtl/burst_addr_seq_chk.sv
`timescale 1ns/1ps
module burst_addr_seq_chk
  import burst_seq_pkg::*;
#(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          addr_valid,
  input logic [AW-1:0] addr_in,
  input logic          io_space,
  input logic          phase_done,
  input logic [AW-1:0] cur_addr,
  input logic          disc_req,
  input logic          be_err,
  input order_e        order_q,
  input logic          io_q
);
  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |=> cur_addr[AW-1:2] == $past(addr_in[AW-1:2]));

  assert_mem_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !io_q |-> cur_addr[1:0] == 2'b00);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_valid && !phase_done) |=> $stable(cur_addr));

  assert_linear_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_valid && phase_done && order_q == ORD_LINEAR) |=> cur_addr == $past(cur_addr) + AW'(4));

  assert_disc_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (disc_req && !addr_valid) |=> disc_req);

  assert_no_disc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (order_q != ORD_RSVD) |-> !disc_req);

  assert_err_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    be_err |-> ($past(addr_valid) && $past(io_space)));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .addr_valid (addr_valid),
  .addr_in    (addr_in),
  .io_space   (io_space),
  .phase_done (phase_done),
  .cur_addr   (cur_addr),
  .disc_req   (disc_req),
  .be_err     (be_err),
  .order_q    (order_q),
  .io_q       (io_q)
);

// File: tb/tb_burst_addr_seq.sv
`timescale 1ns/1ps
module tb_burst_addr_seq;
  logic        clk;
  logic        rst_n;
  logic        addr_valid;
  logic [31:0] addr_in;
  logic        io_space;
  logic [3:0]  be_n;
  logic        phase_done;
  logic [4:0]  line_dw;
  logic [31:0] cur_addr, cur_nw;
  logic        disc_req, disc_nw;
  logic        be_err, be_err_nw;

  int n_chk = 0;
  int n_err = 0;

  burst_addr_seq dut (
    .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .addr_in(addr_in),
    .io_space(io_space), .be_n(be_n), .phase_done(phase_done), .line_dw(line_dw),
    .cur_addr(cur_addr), .disc_req(disc_req), .be_err(be_err));

  burst_addr_seq #(.WRAP_EN(1'b0)) dut_nw (
    .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .addr_in(addr_in),
    .io_space(io_space), .be_n(be_n), .phase_done(phase_done), .line_dw(line_dw),
    .cur_addr(cur_nw), .disc_req(disc_nw), .be_err(be_err_nw));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic start(input logic [31:0] a, input logic io, input logic [3:0] be, input logic [4:0] ls);
    addr_valid = 1'b1; addr_in = a; io_space = io; be_n = be; line_dw = ls;
    cyc();
    addr_valid = 1'b0;
  endtask

  // one data phase; returns disc_req seen while the phase completes
  task automatic step(output logic d, output logic dn);
    phase_done = 1'b1;
    #1;
    d = disc_req; dn = disc_nw;
    cyc();
    phase_done = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; addr_valid = 0; addr_in = 0; io_space = 0; be_n = 4'hF;
    phase_done = 0; line_dw = 5'd4;
    repeat (3) cyc();
    chk("R1 addr in reset", cur_addr, 0);
    chk("R1 disc in reset", {31'b0, disc_req}, 0);
    rst_n = 1'b1;
    repeat (3) cyc();
    chk("R1 addr after reset", cur_addr, 0);
    chk("R1 disc after reset", {31'b0, disc_req}, 0);
    chk("R1 err after reset", {31'b0, be_err}, 0);
  endtask

  // generic wrap/linear run with independent expected sequence
  task automatic t_run(input string req, input logic [31:0] a, input logic [4:0] ls, input bit wrap, input int n);
    logic d, dn;
    int   lsz, off0;
    logic [31:0] base, exp;
    start(a, 1'b0, 4'h0, ls);
    lsz  = wrap ? int'(ls) : 1;
    base = {a[31:2], 2'b00} & ~(32'(lsz * 4) - 1);
    off0 = int'(a[31:2]) % lsz;
    for (int i = 0; i <= n; i++) begin
      if (wrap) exp = base + 32'((i / lsz) * lsz * 4) + 32'(((off0 + i) % lsz) * 4);
      else      exp = {a[31:2], 2'b00} + 32'(i * 4);
      chk(req, cur_addr, exp);
      if (i < n) begin
        step(d, dn);
        chk({req, " no disc"}, {31'b0, d}, 0);
      end
    end
  endtask

  task automatic t_linear();
    logic d, dn;
    start(32'h1000_0100, 1'b0, 4'h0, 5'd4);
    chk("R2 load", cur_addr, 32'h1000_0100);
    cyc(); cyc();
    chk("R3 hold idle", cur_addr, 32'h1000_0100);
    for (int i = 1; i <= 3; i++) begin
      step(d, dn);
      chk("R3 linear step", cur_addr, 32'h1000_0100 + 32'(4 * i));
      chk("R4 no disc linear", {31'b0, d}, 0);
    end
  endtask

  task automatic t_reserved(input logic [1:0] code);
    logic d, dn;
    start(32'h0000_2000 | {30'b0, code}, 1'b0, 4'h0, 5'd4);
    chk("R2 reserved load clears low bits", cur_addr, 32'h2000);
    chk("R4 no disc before first phase", {31'b0, disc_req}, 0);
    step(d, dn);
    chk("R4 disc during first phase", {31'b0, d}, 1);
    cyc(); cyc();
    chk("R4 disc held", {31'b0, disc_req}, 1);
    start(32'h0000_3000, 1'b0, 4'h0, 5'd4);
    chk("R4 disc cleared by new address", {31'b0, disc_req}, 0);
  endtask

  task automatic t_nowrap();
    logic d, dn;
    start(32'h0000_000A, 1'b0, 4'h0, 5'd4);
    step(d, dn);
    chk("R8 no-wrap disc", {31'b0, dn}, 1);
    chk("R8 wrap instance no disc", {31'b0, d}, 0);
    chk("R8 no-wrap linear", cur_nw, 32'h0C);
    step(d, dn);
    chk("R8 no-wrap linear 2", cur_nw, 32'h10);
    chk("R5 wrap instance wraps", cur_addr, 32'h00);
  endtask

  task automatic t_line_sample();
    logic d, dn;
    logic [31:0] expv [5] = '{32'h08, 32'h0C, 32'h00, 32'h04, 32'h18};
    start(32'h0000_000A, 1'b0, 4'h0, 5'd4);
    line_dw = 5'd16;
    for (int i = 0; i < 5; i++) begin
      chk("R9 line size sampled at start", cur_addr, expv[i]);
      if (i < 4) step(d, dn);
    end
  endtask

  task automatic t_bad_line(input logic [4:0] ls);
    logic d, dn;
    start(32'h0000_000A, 1'b0, 4'h0, ls);
    for (int i = 0; i < 3; i++) begin
      chk("R10 illegal size gives linear", cur_addr, 32'h08 + 32'(4 * i));
      step(d, dn);
      chk("R10 illegal size no disc", {31'b0, d}, 0);
    end
  endtask

  task automatic t_io(input logic [31:0] a, input logic [3:0] be, input logic exp_err);
    logic d, dn;
    start(a, 1'b1, be, 5'd4);
    chk("R11 be_err at address phase", {31'b0, be_err}, {31'b0, exp_err});
    chk("R12 io load keeps byte address", cur_addr, a);
    step(d, dn);
    chk("R11 be_err one cycle", {31'b0, be_err}, 0);
    chk("R12 io step by 4", cur_addr, a + 32'd4);
    chk("R12 io no disc", {31'b0, d}, 0);
  endtask

  task automatic t_priority();
    logic d, dn;
    start(32'h0000_0500, 1'b0, 4'h0, 5'd4);
    step(d, dn);
    addr_valid = 1'b1; phase_done = 1'b1; addr_in = 32'h0000_0900; io_space = 1'b0;
    cyc();
    addr_valid = 1'b0; phase_done = 1'b0;
    chk("R13 address phase wins", cur_addr, 32'h0900);
    step(d, dn);
    chk("R13 next phase from new address", cur_addr, 32'h0904);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    t_reset();
    t_linear();
    t_reserved(2'b01);
    t_reserved(2'b11);
    t_run("R5 R6 wrap L4 start 8", 32'h0000_000A, 5'd4, 1'b1, 9);
    t_run("R5 R6 wrap L8 mid", 32'h0000_1016, 5'd8, 1'b1, 10);
    t_run("R5 R6 wrap L16 last", 32'h0000_003E, 5'd16, 1'b1, 18);
    t_run("R5 R6 wrap L2", 32'h0000_0106, 5'd2, 1'b1, 5);
    t_run("R7 aligned wrap equals linear", 32'h0000_0042, 5'd4, 1'b0, 6);
    t_nowrap();
    t_line_sample();
    t_bad_line(5'd3);
    t_bad_line(5'd0);
    t_io(32'h0000_0303, 4'b0111, 1'b0);
    t_io(32'h0000_0303, 4'b0011, 1'b1);
    t_io(32'h0000_0300, 4'b1110, 1'b0);
    t_io(32'h0000_0300, 4'b1111, 1'b1);
    t_io(32'h0000_0301, 4'b0101, 1'b0);
    t_io(32'h0000_0301, 4'b1100, 1'b1);
    t_io(32'h0000_0302, 4'b1011, 1'b0);
    t_io(32'h0000_0302, 4'b1010, 1'b1);
    t_priority();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule